// File: doc/BRIEF.md
# Multichannel Converter Serial Command Port

This block is the device-side serial port of an eight-channel 16-bit converter. A host drives chip select (active low), a serial clock and a serial data line. The port samples that line on rising serial-clock edges while chip select is low and looks for a start bit. Once it has one, it collects an 8-bit word and acts on it. A word can write a per-channel configuration register, set the operating mode, or ask the converter for a conversion on a chosen channel. The converter is outside the block. It receives a one-cycle request with a channel number and later returns a 16-bit offset-binary code with a valid strobe. That code then leaves on the serial output MSB first, moving one bit on each falling serial-clock edge.

When a start bit may be taken depends on the operating mode. In each mode, the next command is allowed to begin before the tail of the current result has left, and the point where it may begin differs by mode. Command bits and result bits then share the same serial-clock cycles.

The block runs on a system clock. Chip select, the serial clock and the data line each pass through a two-stage synchroniser, and an edge acts in the third system clock after the pin changes. The serial clock must therefore stay at each level for at least four system clocks. Two state machines do the work. The command machine has the states HUNT, RECV and EXEC. It takes HUNT to RECV on an accepted start bit, RECV to EXEC on the eighth word bit, RECV to HUNT when chip select rises, and EXEC to HUNT always. The result machine has the states IDLE, BUSY and SEND. It takes IDLE to BUSY on a conversion word, BUSY to SEND on the result strobe, SEND to IDLE after the sixteenth falling edge, and SEND to BUSY on a new conversion word.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset, every channel reads single-ended (`cfg_diff` bit 0) with range code 0, `mode` is 0, `dout` is 0 and `conv_start` is low.
- R2: The data line is sampled only on rising serial-clock edges with chip select low. A start bit is the first high sample taken while the start condition holds. Low samples, and high samples taken while the condition does not hold, are not treated as command content.
- R3: With no conversion pending and either no result yet delivered or all 16 result bits shifted out, the next high sample is taken as a start bit.
- R4: While a result is being shifted, the start condition holds once the following number of falling edges have passed since the result was loaded: 13 in mode 0 (B15 to B3 gone), 9 in mode 1 (B15 to B7 gone), 12 in mode 2 (B15 to B4 gone) and 16 in mode 3. From a conversion request until its result arrives, no start bit is taken.
- R5: A word is the 8 samples after the start bit, first sample in word bit 7. If bit 7 is 0, the word is a configuration word. If bits 7:6 are 10, the word is a conversion word: bits 5:3 give the channel, and `conv_start` pulses high for exactly one cycle with that channel on `conv_ch`. If bits 7:6 are 11, bits 5:4 are written to `mode`.
- R6: A configuration word has the channel in bits 6:4, the differential flag in bit 3 and the range code in bits 2:0. It changes only that channel: `cfg_diff[ch]` and `cfg_range[3*ch+2:3*ch]`. No other channel changes.
- R7: `res_valid` during a pending conversion loads `res_data`. `dout` then shows B15, advances one bit after each falling serial-clock edge with chip select low, and returns to 0 after the sixteenth such edge. `res_valid` with no conversion pending is ignored.
- R8: Raising chip select drops a partly received word and returns to HUNT. `dout_oe` is low while chip select is high. Serial-clock edges while chip select is high have no effect.
- R9: A word accepted during a result shift is received on the same serial-clock cycles in which the remaining result bits leave, and neither stream disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output drive enable; the pad floats when low |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | 3 | Channel of the latest conversion request |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | 16 | Converter result, offset binary |
| cfg_diff | output | 8 | Per-channel differential flag |
| cfg_range | output | 24 | Per-channel 3-bit range code, channel n at bits 3n+2:3n |
| mode | output | 2 | Operating mode |

## Verification
A wrong threshold or a wrong result-machine state makes the port take a start bit one or more bits early or late. The word boundary then shifts, and a configuration word lands on the wrong channel or carries wrong fields. This shows at `cfg_diff` and `cfg_range` within one word time, and the reference model checks it after every word. A wrong shift-register state shows as a wrong `dout` bit at the very next bit sample. A wrong command-machine state shows at `cfg_range` or at `conv_start` within eight serial-clock periods.

// File: rtl/acp_pkg.sv
package acp_pkg;

    typedef enum logic [1:0] {
        CMD_HUNT = 2'd0,
        CMD_RECV = 2'd1,
        CMD_EXEC = 2'd2
    } cmd_state_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_BUSY = 2'd1,
        TX_SEND = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        MODE_EXT_CLK  = 2'd0,
        MODE_EXT_ACQ  = 2'd1,
        MODE_INT_CLK  = 2'd2,
        MODE_FULL_OUT = 2'd3
    } op_mode_t;

    // Falling edges that must pass before a new start bit is taken.
    function automatic int unsigned start_after(op_mode_t m, int unsigned res_w);
        int unsigned n;
        unique case (m)
            MODE_EXT_CLK:  n = res_w - 3;
            MODE_EXT_ACQ:  n = res_w - 7;
            MODE_INT_CLK:  n = res_w - 4;
            MODE_FULL_OUT: n = res_w;
            default:       n = res_w;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/acp_sync.sv
module acp_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_sync = stage[STAGES-1];

endmodule

// File: rtl/acp_cmd_fsm.sv
module acp_cmd_fsm
    import acp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              sclk_rise,
    input  logic              din_bit,
    input  logic              start_ok,
    output cmd_state_t        state,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);

    localparam int CNT_W = $clog2(WORD_W);

    cmd_state_t       state_nx;
    logic [CNT_W-1:0] bit_cnt;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            CMD_HUNT: if (cs_low && sclk_rise && din_bit && start_ok) state_nx = CMD_RECV;
            CMD_RECV: begin
                if (!cs_low)
                    state_nx = CMD_HUNT;
                else if (sclk_rise && bit_cnt == CNT_W'(WORD_W - 1))
                    state_nx = CMD_EXEC;
            end
            CMD_EXEC: state_nx = CMD_HUNT;
            default:  state_nx = CMD_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_HUNT;
        else        state <= state_nx;
    end

    // word shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            word    <= '0;
        end else if (state == CMD_HUNT && state_nx == CMD_RECV) begin
            bit_cnt <= '0;
            word    <= '0;
        end else if (state == CMD_RECV && cs_low && sclk_rise) begin
            word    <= {word[WORD_W-2:0], din_bit};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        word_done = (state == CMD_EXEC);
    end

endmodule

// File: rtl/acp_cfg_bank.sv
module acp_cfg_bank
    import acp_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int RNG_W  = 3,
    parameter int WORD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_done,
    input  logic [WORD_W-1:0]       word,
    output logic [NUM_CH-1:0]       cfg_diff,
    output logic [NUM_CH*RNG_W-1:0] cfg_range,
    output op_mode_t                mode,
    output logic                    conv_go,
    output logic [CH_W-1:0]         conv_ch,
    output logic                    conv_start
);

    localparam int KIND_BIT = WORD_W - 1;
    localparam int SUB_BIT  = WORD_W - 2;
    localparam int MODE_W   = $bits(op_mode_t);

    logic              is_cfg, is_mode;
    logic [CH_W-1:0]   cfg_sel, conv_sel;
    logic [RNG_W-1:0]  rng_new;
    logic              diff_new;
    logic [MODE_W-1:0] mode_new;

    always_comb begin
        is_cfg   = word_done && !word[KIND_BIT];
        conv_go  = word_done && word[KIND_BIT] && !word[SUB_BIT];
        is_mode  = word_done && word[KIND_BIT] && word[SUB_BIT];
        cfg_sel  = word[WORD_W-2 -: CH_W];
        diff_new = word[RNG_W];
        rng_new  = word[RNG_W-1:0];
        conv_sel = word[WORD_W-3 -: CH_W];
        mode_new = word[WORD_W-3 -: MODE_W];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_diff[g]                  <= 1'b0;
                cfg_range[g*RNG_W +: RNG_W]  <= '0;
            end else if (is_cfg && cfg_sel == CH_W'(g)) begin
                cfg_diff[g]                  <= diff_new;
                cfg_range[g*RNG_W +: RNG_W]  <= rng_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= MODE_EXT_CLK;
            conv_ch    <= '0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= conv_go;
            if (conv_go) conv_ch <= conv_sel;
            if (is_mode) mode    <= op_mode_t'(mode_new);
        end
    end

endmodule

// File: rtl/acp_result_tx.sv
module acp_result_tx
    import acp_pkg::*;
#(
    parameter int RES_W  = 16,
    parameter int SENT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              sclk_fall,
    input  logic              conv_go,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  op_mode_t          mode,
    output tx_state_t         state,
    output logic [SENT_W-1:0] sent,
    output logic              dout_bit,
    output logic              start_ok
);

    tx_state_t        state_nx;
    logic [RES_W-1:0] shreg;
    logic             shift;

    assign shift = cs_low && sclk_fall;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (conv_go) state_nx = TX_BUSY;
            TX_BUSY: if (res_valid) state_nx = TX_SEND;
            TX_SEND: begin
                if (conv_go)
                    state_nx = TX_BUSY;
                else if (shift && sent == SENT_W'(RES_W - 1))
                    state_nx = TX_IDLE;
            end
            default: state_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    // result shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sent  <= '0;
        end else if (state == TX_BUSY && res_valid) begin
            shreg <= res_data;
            sent  <= '0;
        end else if (state == TX_SEND && shift) begin
            shreg <= {shreg[RES_W-2:0], 1'b0};
            sent  <= sent + 1'b1;
        end
    end

    // outputs
    always_comb begin
        dout_bit = 1'b0;
        start_ok = 1'b0;
        unique case (state)
            TX_IDLE: start_ok = 1'b1;
            TX_BUSY: start_ok = 1'b0;
            TX_SEND: begin
                dout_bit = shreg[RES_W-1];
                start_ok = (32'(sent) >= start_after(mode, RES_W));
            end
            default: start_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
    import acp_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int RNG_W       = 3,
    parameter int RES_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cs_n,
    input  logic                           sclk,
    input  logic                           din,
    output logic                           dout,
    output logic                           dout_oe,
    output logic                           conv_start,
    output logic [$clog2(NUM_CH)-1:0]      conv_ch,
    input  logic                           res_valid,
    input  logic [RES_W-1:0]               res_data,
    output logic [NUM_CH-1:0]              cfg_diff,
    output logic [NUM_CH*RNG_W-1:0]        cfg_range,
    output logic [1:0]                     mode
);

    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WORD_W = CH_W + RNG_W + 2;
    localparam int SENT_W = $clog2(RES_W + 1);

    logic [2:0]        pin_s;
    logic              sclk_q;
    logic              cs_low, sclk_rise, sclk_fall, din_bit;
    logic              start_ok, word_done, conv_go, dout_bit;
    logic [WORD_W-1:0] word;
    logic [SENT_W-1:0] tx_sent;
    cmd_state_t        cmd_st;
    tx_state_t         tx_st;
    op_mode_t          mode_q;

    acp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({din, sclk, cs_n}),
        .q_sync  (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= pin_s[1];
    end

    assign cs_low    = !pin_s[0];
    assign sclk_rise = pin_s[1] && !sclk_q;
    assign sclk_fall = !pin_s[1] && sclk_q;
    assign din_bit   = pin_s[2];

    acp_cmd_fsm #(.WORD_W(WORD_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (cs_low),
        .sclk_rise (sclk_rise),
        .din_bit   (din_bit),
        .start_ok  (start_ok),
        .state     (cmd_st),
        .word_done (word_done),
        .word      (word)
    );

    acp_cfg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RNG_W(RNG_W), .WORD_W(WORD_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (word_done),
        .word       (word),
        .cfg_diff   (cfg_diff),
        .cfg_range  (cfg_range),
        .mode       (mode_q),
        .conv_go    (conv_go),
        .conv_ch    (conv_ch),
        .conv_start (conv_start)
    );

    acp_result_tx #(.RES_W(RES_W), .SENT_W(SENT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (cs_low),
        .sclk_fall (sclk_fall),
        .conv_go   (conv_go),
        .res_valid (res_valid),
        .res_data  (res_data),
        .mode      (mode_q),
        .state     (tx_st),
        .sent      (tx_sent),
        .dout_bit  (dout_bit),
        .start_ok  (start_ok)
    );

    assign dout    = dout_bit;
    assign dout_oe = cs_low;
    assign mode    = mode_q;

endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk
    import acp_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RNG_W  = 3,
    parameter int RES_W  = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input cmd_state_t                     cmd_st,
    input tx_state_t                      tx_st,
    input logic                           start_ok,
    input logic                           cs_low,
    input logic                           sclk_fall,
    input logic                           conv_go,
    input logic [$clog2(RES_W+1)-1:0]     tx_sent,
    input logic                           conv_start,
    input logic [NUM_CH-1:0]              cfg_diff,
    input logic [NUM_CH*RNG_W-1:0]        cfg_range,
    input logic [1:0]                     mode,
    input logic                           dout
);

    localparam int SENT_W = $clog2(RES_W + 1);

    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_st == CMD_HUNT && !start_ok) |=> (cmd_st == CMD_HUNT));  // R2

    AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st == TX_BUSY && cmd_st == CMD_HUNT) |=> (cmd_st == CMD_HUNT));  // R4

    AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);  // R5

    AST_CONV_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |=> (tx_st == TX_BUSY));  // R5

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_st != CMD_EXEC) |=> $stable(mode));  // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_st != CMD_EXEC) |=> ($stable(cfg_diff) && $stable(cfg_range)));  // R6

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st == TX_SEND && !(cs_low && sclk_fall) && !conv_go) |=> $stable(dout));  // R7

    AST_SENT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st == TX_SEND) |-> (tx_sent < SENT_W'(RES_W)));  // R7

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_st == CMD_RECV && !cs_low) |=> (cmd_st == CMD_HUNT));  // R8

endmodule

bind adc_cmd_port adc_cmd_port_chk #(
    .NUM_CH (NUM_CH),
    .RNG_W  (RNG_W),
    .RES_W  (RES_W)
) u_chk (.*);

// File: tb/adc_cmd_port_tb.sv
module adc_cmd_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 4;
    localparam int STUB_DLY   = 60;
    localparam int WDOG_CLKS  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        dout, dout_oe, conv_start;
    logic [2:0]  conv_ch;
    logic        stub_v = 1'b0, spur_v = 1'b0;
    logic        res_valid;
    logic [15:0] res_data = '0;
    logic [7:0]  cfg_diff;
    logic [23:0] cfg_range;
    logic [1:0]  mode;

    assign res_valid = stub_v | spur_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .conv_start(conv_start), .conv_ch(conv_ch),
        .res_valid(res_valid), .res_data(res_data),
        .cfg_diff(cfg_diff), .cfg_range(cfg_range), .mode(mode)
    );

    int n_chk = 0, n_fail = 0, n_conv_seen = 0, stub_n = 0;
    bit finished = 0;

    // reference model state
    bit       m_cs_low = 0, m_hunt = 1;
    int       m_cnt = 0, m_tx = 0, m_sent = 0, m_mode = 0, m_nconv = 0;
    bit [7:0] m_word = 0;
    bit [2:0] m_conv_ch = 0;
    bit [15:0] m_res = 0;
    bit       m_diff [8];
    bit [2:0] m_rng [8];

    function automatic logic [15:0] stub_val(input int ch, input int n);
        return 16'(32'h8000 + ch * 32'h0913 + n * 32'h0161);
    endfunction

    function automatic int thr(input int m);
        case (m)
            0: return 13;
            1: return 9;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic bit m_start_ok();
        if (m_tx == 0) return 1;
        if (m_tx == 1) return 0;
        return m_sent >= thr(m_mode);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_exec();
        if (!m_word[7]) begin
            m_diff[m_word[6:4]] = m_word[3];
            m_rng[m_word[6:4]]  = m_word[2:0];
        end else if (!m_word[6]) begin
            m_tx = 1;
            m_conv_ch = m_word[5:3];
        end else begin
            m_mode = int'(m_word[5:4]);
        end
    endtask

    task automatic model_rise(input bit d);
        if (!m_cs_low) return;
        if (m_hunt) begin
            if (d && m_start_ok()) begin
                m_hunt = 0; m_cnt = 0; m_word = 0;
            end
        end else begin
            m_word = {m_word[6:0], d};
            m_cnt++;
            if (m_cnt == 8) begin
                m_hunt = 1;
                m_exec();
            end
        end
    endtask

    task automatic model_fall();
        if (m_cs_low && m_tx == 2) begin
            m_sent++;
            if (m_sent == 16) m_tx = 0;
        end
    endtask

    // one serial bit: low phase, dout sample, high phase
    task automatic bit_clk(input bit d);
        logic expb;
        din = d;
        repeat (HALF_CLKS) @(negedge clk);
        if (m_cs_low) begin
            expb = (m_tx == 2) ? m_res[15 - m_sent] : 1'b0;
            chk((!m_hunt && m_tx == 2) ? "R9 dout during word" : "R7 dout bit", dout, expb);
        end
        sclk = 1'b1;
        model_rise(d);
        repeat (HALF_CLKS) @(negedge clk);
        sclk = 1'b0;
        model_fall();
    endtask

    task automatic send_word(input bit [7:0] w);
        int guard = 0;
        do begin
            bit_clk(1'b1);
            guard++;
        end while (m_hunt && guard < 40);
        for (int i = 7; i >= 0; i--) bit_clk(w[i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic drain();
        while (m_tx == 2) bit_clk(1'b0);
    endtask

    task automatic conv_wait();
        repeat (STUB_DLY + 12) @(negedge clk);
        m_tx = 2; m_sent = 0;
        m_res = stub_val(int'(m_conv_ch), m_nconv);
        m_nconv++;
        chk("R5 conversion request count", n_conv_seen, m_nconv);
    endtask

    task automatic check_cfg();
        for (int c = 0; c < 8; c++) begin
            chk("R6 diff flag", cfg_diff[c], m_diff[c]);
            chk("R6 range code", cfg_range[c*3 +: 3], m_rng[c]);
        end
        chk("R5 mode", mode, m_mode);
    endtask

    // converter stand-in
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                int ch;
                ch = int'(conv_ch);
                repeat (STUB_DLY) @(negedge clk);
                res_data = stub_val(ch, stub_n);
                stub_v = 1'b1;
                @(negedge clk);
                stub_v = 1'b0;
                stub_n++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) n_conv_seen++;
        end
    end

    initial begin
        repeat (WDOG_CLKS) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) begin m_diff[c] = 0; m_rng[c] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 cfg_diff", cfg_diff, 0);
        chk("R1 cfg_range", cfg_range, 0);
        chk("R1 mode", mode, 0);
        chk("R1 dout", dout, 0);
        chk("R1 conv_start", conv_start, 0);
        chk("R8 dout_oe with cs high", dout_oe, 0);

        cs_n = 1'b0; m_cs_low = 1;
        repeat (6) @(negedge clk);
        chk("R8 dout_oe with cs low", dout_oe, 1);

        // R2 leading low samples are not a start; R3 idle start
        bit_clk(1'b0); bit_clk(1'b0); bit_clk(1'b0);
        send_word({1'b0, 3'd5, 1'b1, 3'd6});
        send_word({1'b0, 3'd0, 1'b0, 3'd3});
        send_word({1'b0, 3'd7, 1'b1, 3'd1});
        check_cfg();

        // R4 thresholds per mode, with overlapped config words (R9)
        for (int m = 0; m < 4; m++) begin
            bit [2:0] tch;
            send_word({2'b11, 2'(m), 4'b0101});
            chk("R5 mode word", mode, m);
            send_word({2'b10, 3'(m + 2), 3'b011});
            bit_clk(1'b1); bit_clk(1'b1);          // R4 ignored while converting
            conv_wait();
            tch = 3'(m + 1);
            send_word({1'b0, tch, m[0], 3'(5 - m)});
            chk("R9 overlapped word diff", cfg_diff[tch], m_diff[tch]);
            chk("R4 overlapped word range", cfg_range[tch*3 +: 3], m_rng[tch]);
            drain();
            bit_clk(1'b0);
            check_cfg();
        end

        // R8 abort a partial word
        bit_clk(1'b1); bit_clk(1'b0); bit_clk(1'b1); bit_clk(1'b0); bit_clk(1'b1);
        cs_n = 1'b1; m_cs_low = 0; m_hunt = 1;
        repeat (6) @(negedge clk);
        chk("R8 dout_oe after abort", dout_oe, 0);
        for (int i = 0; i < 5; i++) bit_clk(1'b1);
        cs_n = 1'b0; m_cs_low = 1;
        repeat (6) @(negedge clk);
        send_word({1'b0, 3'd2, 1'b0, 3'd5});
        check_cfg();

        // R7 stray result strobe with nothing pending
        @(negedge clk); spur_v = 1'b1;
        @(negedge clk); spur_v = 1'b0;
        bit_clk(1'b0); bit_clk(1'b0); bit_clk(1'b0);
        send_word({1'b0, 3'd4, 1'b1, 3'd7});
        check_cfg();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule